// File: doc/BRIEF.md
# Quarter-Rate Quadrature Upconverter

This block shifts a complex baseband stream up to a carrier at exactly one quarter of the output sample rate, without multipliers or a sine table. On each clock it takes a beat of `LANES` parallel signed I and Q samples and returns `LANES` parallel real samples. The output beat is intended for the parallel lanes of a fast DAC serializer. Every input sample meets exactly one oscillator sample. No sample is ever held across several oscillator phases.

The oscillator has four phases, so each output sample needs only sign changes and at most one addition. A runtime select picks one of two patterns. The on-axis pattern has unity gain and uses no adders. The pattern rotated by 45 degrees has a numerical gain of √2. When the lane count is not a multiple of four, the phase of lane 0 walks from beat to beat, so the carrier stays continuous across beats.

Top module: `qrate_upconv`

## Requirements
- R1: While `rst` is high at a clock edge, the following hold after that edge. `out_valid` is 0 and `out_data` is all zeros. The beat phase is 0 and the held oscillator mode is on-axis.
- R2: `out_valid` equals the value `in_valid` had at the previous edge. `out_data` takes a new value only after an edge at which `in_valid` was high. Otherwise it keeps its value.
- R3: In on-axis mode (`rotate_sel` = 0), the output at oscillator phase 0 is +I, at phase 1 −Q, at phase 2 −I and at phase 3 +Q. Each result is sign-extended to `IN_W`+1 bits.
- R4: In rotated mode (`rotate_sel` = 1), the output at phase 0 is I+Q, at phase 1 I−Q, at phase 2 −I−Q and at phase 3 −I+Q.
- R5: Lane k uses oscillator phase (P + k) mod 4, where P is the beat phase. P is 0 after reset and advances by `LANES` mod 4 on every beat with `in_valid` high. P does not change while `in_valid` is low.
- R6: The block samples `rotate_sel` only on valid beats whose beat phase P is 0. The sampled mode applies to that beat and to every later beat up to the next such sampling beat. On other beats the input has no effect.
- R7: In rotated mode at phase 2 with I = Q = −2^(IN_W−1), the output saturates to 2^IN_W − 1. Every other case is exact.
- R8: In on-axis mode, negating I = −2^(IN_W−1) at phase 2 gives exactly +2^(IN_W−1) with no wrap.
- R9: Lane k occupies bits [k·`IN_W` +: `IN_W`] of `i_data` and `q_data`. It occupies bits [k·(`IN_W`+1) +: `IN_W`+1] of `out_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input beat valid |
| rotate_sel | input | 1 | Oscillator pattern: 0 on-axis, 1 rotated by 45° |
| i_data | input | LANES·IN_W | In-phase samples, lane 0 in the low bits |
| q_data | input | LANES·IN_W | Quadrature samples, lane 0 in the low bits |
| out_valid | output | 1 | Output beat valid |
| out_data | output | LANES·(IN_W+1) | Real output samples, lane 0 in the low bits |

## Verification
Every result passes through one register stage. A beat presented before clock edge t therefore appears on `out_data` and `out_valid` right after edge t. The beat phase and the held mode take their new values at that same edge. The bench changes its inputs on the falling edge and computes each beat's expected lanes before the rising edge. It compares them on the next falling edge, half a period after the register loads. On idle beats it compares against the unchanged previous expectation. A second instance with six lanes exercises the beat phase walking through 0 and 2, the mode select being ignored on phase-2 beats, and all four phases on the extreme inputs.

// File: rtl/qru_pkg.sv
package qru_pkg;

  typedef logic [1:0] osc_phase_t;

  typedef enum logic {
    OSC_AXIS = 1'b0,
    OSC_ROT  = 1'b1
  } osc_mode_e;

  // Oscillator phase seen by a lane at offset k from the beat phase
  function automatic osc_phase_t lane_phase(osc_phase_t beat_ph, int unsigned k);
    lane_phase = beat_ph + osc_phase_t'(k % 4);
  endfunction

endpackage

// File: rtl/qru_phase_ctrl.sv
module qru_phase_ctrl #(
  parameter int LANES = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic                rotate_sel,
  output qru_pkg::osc_phase_t beat_phase,
  output qru_pkg::osc_mode_e  mode_eff,
  output qru_pkg::osc_mode_e  mode_held
);
  import qru_pkg::*;

  localparam osc_phase_t STEP = osc_phase_t'(LANES % 4);

  osc_phase_t ph_q;
  osc_mode_e  mode_q;
  logic       at_boundary;

  assign at_boundary = (ph_q == 2'd0);
  assign mode_eff    = at_boundary ? osc_mode_e'(rotate_sel) : mode_q;
  assign beat_phase  = ph_q;
  assign mode_held   = mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q   <= '0;
      mode_q <= OSC_AXIS;
    end else if (in_valid) begin
      ph_q <= ph_q + STEP;
      if (at_boundary) mode_q <= osc_mode_e'(rotate_sel);
    end
  end

endmodule

// File: rtl/qru_lane.sv
module qru_lane #(
  parameter int IN_W     = 16,
  parameter int LANE_IDX = 0,
  localparam int OUT_W   = IN_W + 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  qru_pkg::osc_phase_t beat_phase,
  input  qru_pkg::osc_mode_e  mode,
  input  logic [IN_W-1:0]     i_s,
  input  logic [IN_W-1:0]     q_s,
  output logic [OUT_W-1:0]    y
);
  import qru_pkg::*;

  localparam logic signed [OUT_W-1:0] OUT_MIN = {1'b1, {(OUT_W-1){1'b0}}};
  localparam logic signed [OUT_W-1:0] OUT_MAX = {1'b0, {(OUT_W-1){1'b1}}};

  // Negation that clips the single unrepresentable value
  function automatic logic signed [OUT_W-1:0] neg_sat(logic signed [OUT_W-1:0] v);
    neg_sat = (v == OUT_MIN) ? OUT_MAX : -v;
  endfunction

  function automatic logic signed [OUT_W-1:0] mix(
    osc_mode_e m, osc_phase_t p, logic [IN_W-1:0] iv, logic [IN_W-1:0] qv);
    logic signed [OUT_W-1:0] ie, qe, sum, dif;
    ie  = {iv[IN_W-1], iv};
    qe  = {qv[IN_W-1], qv};
    sum = ie + qe;
    dif = ie - qe;
    if (m == OSC_AXIS) begin
      case (p)
        2'd0:    mix = ie;
        2'd1:    mix = -qe;
        2'd2:    mix = -ie;
        default: mix = qe;
      endcase
    end else begin
      case (p)
        2'd0:    mix = sum;
        2'd1:    mix = dif;
        2'd2:    mix = neg_sat(sum);
        default: mix = -dif;
      endcase
    end
  endfunction

  osc_phase_t my_phase;
  assign my_phase = lane_phase(beat_phase, LANE_IDX);

  always_ff @(posedge clk) begin
    if (rst)           y <= '0;
    else if (in_valid) y <= mix(mode, my_phase, i_s, q_s);
  end

endmodule

// File: rtl/qrate_upconv.sv
module qrate_upconv #(
  parameter int LANES = 4,
  parameter int IN_W  = 16,
  localparam int OUT_W = IN_W + 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic                   rotate_sel,
  input  logic [LANES*IN_W-1:0]  i_data,
  input  logic [LANES*IN_W-1:0]  q_data,
  output logic                   out_valid,
  output logic [LANES*OUT_W-1:0] out_data
);
  import qru_pkg::*;

  osc_phase_t phase_now;
  osc_mode_e  mode_eff;
  osc_mode_e  mode_held;

  qru_phase_ctrl #(.LANES(LANES)) u_phase (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .rotate_sel (rotate_sel),
    .beat_phase (phase_now),
    .mode_eff   (mode_eff),
    .mode_held  (mode_held)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    qru_lane #(.IN_W(IN_W), .LANE_IDX(k)) u_lane (
      .clk        (clk),
      .rst        (rst),
      .in_valid   (in_valid),
      .beat_phase (phase_now),
      .mode       (mode_eff),
      .i_s        (i_data[k*IN_W +: IN_W]),
      .q_s        (q_data[k*IN_W +: IN_W]),
      .y          (out_data[k*OUT_W +: OUT_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= in_valid;
  end

endmodule

// File: rtl/qru_checker.sv
module qru_checker #(
  parameter int LANES = 4,
  parameter int IN_W  = 16,
  localparam int OUT_W = IN_W + 1
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   in_valid,
  input logic [LANES*IN_W-1:0]  i_data,
  input logic [LANES*OUT_W-1:0] out_data,
  input logic                   out_valid,
  input logic [1:0]             phase_now,
  input logic                   mode_eff,
  input logic                   mode_held
);
  localparam logic [1:0] STEP = 2'(LANES % 4);

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (!out_valid && phase_now == 2'd0 && !mode_held));

  assert_valid_follow_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_valid_drop_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  assert_data_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_data));

  assert_lane0_axis_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && phase_now == 2'd0 && !mode_eff) |=>
      out_data[OUT_W-1:0] == {$past(i_data[IN_W-1]), $past(i_data[IN_W-1:0])});

  assert_phase_step_R5: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> phase_now == 2'($past(phase_now) + STEP));

  assert_phase_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(phase_now));

  assert_mode_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && phase_now == 2'd0) |=> $stable(mode_held));

endmodule

bind qrate_upconv qru_checker #(.LANES(LANES), .IN_W(IN_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .i_data    (i_data),
  .out_data  (out_data),
  .out_valid (out_valid),
  .phase_now (phase_now),
  .mode_eff  (mode_eff),
  .mode_held (mode_held)
);

// File: tb/qrate_upconv_tb.sv
`timescale 1ns/1ps
module qrate_upconv_tb;
  localparam int W  = 16;
  localparam int OW = W + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic vld = 1'b0;
  logic msel = 1'b0;
  logic [4*W-1:0]  i4, q4;
  logic [6*W-1:0]  i6, q6;
  logic [4*OW-1:0] o4;
  logic [6*OW-1:0] o6;
  logic ov4, ov6;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  int i_s[6], q_s[6];
  int exp4[4], exp6[6];
  int ph4, ph6, mh4, mh6, expv;

  always #2 clk = ~clk;

  qrate_upconv #(.LANES(4), .IN_W(W)) u_dut (
    .clk(clk), .rst(rst), .in_valid(vld), .rotate_sel(msel),
    .i_data(i4), .q_data(q4), .out_valid(ov4), .out_data(o4));

  qrate_upconv #(.LANES(6), .IN_W(W)) u_dut6 (
    .clk(clk), .rst(rst), .in_valid(vld), .rotate_sel(msel),
    .i_data(i6), .q_data(q6), .out_valid(ov6), .out_data(o6));

  // Expected lane value: real part of the sample times the oscillator weight pair
  function automatic int expect_lane(int mode, int p, int iv, int qv);
    int a, b, r;
    if (mode == 0) begin
      a = (p == 0) ? 1 : (p == 2) ? -1 : 0;
      b = (p == 1) ? -1 : (p == 3) ? 1 : 0;
    end else begin
      a = (p < 2) ? 1 : -1;
      b = (p == 0 || p == 3) ? 1 : -1;
    end
    r = iv * a + qv * b;
    if (r > (1 << W) - 1) r = (1 << W) - 1;
    return r;
  endfunction

  task automatic chk(bit ok, string tag, int got, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic model_reset();
    ph4 = 0; ph6 = 0; mh4 = 0; mh6 = 0; expv = 0;
    foreach (exp4[k]) exp4[k] = 0;
    foreach (exp6[k]) exp6[k] = 0;
  endtask

  task automatic check_outputs(string tag);
    chk(ov4 == expv[0], {tag, " valid4"}, int'(ov4), expv);
    chk(ov6 == expv[0], {tag, " valid6"}, int'(ov6), expv);
    for (int k = 0; k < 4; k++) begin
      int got = int'($signed(o4[k*OW +: OW]));
      chk(got == exp4[k], {tag, " lane4"}, got, exp4[k]);
    end
    for (int k = 0; k < 6; k++) begin
      int got = int'($signed(o6[k*OW +: OW]));
      chk(got == exp6[k], {tag, " lane6"}, got, exp6[k]);
    end
  endtask

  // One beat: drive at the falling edge, update the model, check after the next rising edge
  task automatic beat(bit v, bit m, string tag);
    int eff;
    vld = v; msel = m;
    for (int k = 0; k < 6; k++) begin
      i6[k*W +: W] = W'(i_s[k]);
      q6[k*W +: W] = W'(q_s[k]);
      if (k < 4) begin
        i4[k*W +: W] = W'(i_s[k]);
        q4[k*W +: W] = W'(q_s[k]);
      end
    end
    expv = v;
    if (v) begin
      eff = (ph4 == 0) ? int'(m) : mh4;
      if (ph4 == 0) mh4 = m;
      for (int k = 0; k < 4; k++) exp4[k] = expect_lane(eff, (ph4 + k) % 4, i_s[k], q_s[k]);
      ph4 = (ph4 + 4) % 4;
      eff = (ph6 == 0) ? int'(m) : mh6;
      if (ph6 == 0) mh6 = m;
      for (int k = 0; k < 6; k++) exp6[k] = expect_lane(eff, (ph6 + k) % 4, i_s[k], q_s[k]);
      ph6 = (ph6 + 6) % 4;
    end
    @(posedge clk);
    @(negedge clk);
    check_outputs(tag);
  endtask

  task automatic t_reset();
    rst = 1'b1; vld = 1'b0; msel = 1'b0;
    i4 = '0; q4 = '0; i6 = '0; q6 = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    model_reset();
    check_outputs("R1 reset");
    rst = 1'b0;
  endtask

  task automatic t_axis_ramp();
    for (int b = 0; b < 4; b++) begin
      for (int k = 0; k < 6; k++) begin
        i_s[k] = 100 * (b + 1) + k;
        q_s[k] = -(50 * b + 7 * k + 3);
      end
      beat(1'b1, 1'b0, "R3 R5 R9 on-axis");
    end
  endtask

  task automatic t_rotated();
    for (int b = 0; b < 4; b++) begin
      for (int k = 0; k < 6; k++) begin
        i_s[k] = 1000 - 300 * k + 11 * b;
        q_s[k] = 250 * k - 700 + 5 * b;
      end
      beat(1'b1, 1'b1, "R4 rotated");
    end
  endtask

  task automatic t_gaps();
    for (int k = 0; k < 6; k++) begin i_s[k] = 321 + k; q_s[k] = -123 - k; end
    beat(1'b1, 1'b0, "R2 before gap");
    for (int k = 0; k < 6; k++) begin i_s[k] = 9999; q_s[k] = -9999; end
    beat(1'b0, 1'b1, "R2 idle hold");
    beat(1'b0, 1'b0, "R2 idle hold");
    for (int k = 0; k < 6; k++) begin i_s[k] = -40 * k; q_s[k] = 17 * k + 1; end
    beat(1'b1, 1'b0, "R5 after gap");
  endtask

  task automatic t_mode_boundary();
    for (int b = 0; b < 6; b++) begin
      for (int k = 0; k < 6; k++) begin
        i_s[k] = 500 + 13 * k - 20 * b;
        q_s[k] = 200 - 31 * k + 9 * b;
      end
      beat(1'b1, b[0], "R6 mode toggle");
    end
  endtask

  task automatic t_extremes();
    for (int b = 0; b < 4; b++) begin
      for (int k = 0; k < 6; k++) begin i_s[k] = -32768; q_s[k] = -32768; end
      beat(1'b1, 1'b1, "R7 saturate");
    end
    for (int b = 0; b < 2; b++) begin
      for (int k = 0; k < 6; k++) begin i_s[k] = 32767; q_s[k] = (k % 2) ? -32768 : 32767; end
      beat(1'b1, 1'b1, "R7 exact extremes");
    end
    for (int b = 0; b < 4; b++) begin
      for (int k = 0; k < 6; k++) begin i_s[k] = -32768; q_s[k] = -32768; end
      beat(1'b1, 1'b0, "R8 on-axis negate");
    end
  endtask

  initial begin
    model_reset();
    foreach (i_s[k]) begin i_s[k] = 0; q_s[k] = 0; end
    @(negedge clk);
    t_reset();
    t_axis_ramp();
    t_rotated();
    t_gaps();
    t_mode_boundary();
    t_extremes();
    t_reset();
    t_axis_ramp();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule